// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive side of an Ethernet MAC. It watches the byte stream of an incoming frame and takes the six destination address bytes that follow the start-of-frame strobe. It folds the 48-bit address into a 6-bit index and uses that index to select one bit of a 64-bit table that software programs. When the selected bit is set, the block reports a hash match. Two enable inputs control the match: one for unicast addresses and one for multicast addresses.

Software loads the table as two 32-bit words through a simple write port. The receive path drives one byte per valid cycle. Exactly one cycle after the last destination byte is taken, the filter raises a one-cycle verdict strobe. With that strobe come a match flag and a type flag, and both stay on the outputs until the next frame begins. Exact-address matching, broadcast handling, CRC checking and buffering are left to other blocks.

Top module: `dahash_filter`

## Requirements
- R1: Reset clears the whole table and drives `match_vld`, `match_hit` and `match_mc` to 0. Until the table is written, no frame can produce `match_hit` = 1, even with both enables set.
- R2: A write with `tbl_we` = 1 takes effect at the clock edge. With `tbl_sel` = 0, `tbl_wdata` replaces table bits 31:0. With `tbl_sel` = 1, it replaces bits 63:32.
- R3: Address bit 0 is the least significant bit of the first destination byte, and bit 47 is the most significant bit of the sixth. Index bit k (k = 0..5) is the XOR of every address bit j with j mod 6 = k. The index selects table bit `index`.
- R4: `match_hit` is 1 only in two cases. The first is address bit 0 = 1, `mcast_en` = 1 and the indexed bit = 1. The second is address bit 0 = 0, `ucast_en` = 1 and the indexed bit = 1. The enables are sampled in the cycle the sixth byte is taken.
- R5: `match_vld` is a one-cycle pulse. It is high in the cycle right after the clock edge that takes the sixth destination byte.
- R6: `match_mc` equals address bit 0 (1 = multicast). `match_hit` and `match_mc` keep their value until a start of frame, which clears both to 0 at its clock edge.
- R7: A byte is taken only when `rx_valid` = 1. `rx_sof` counts only together with `rx_valid`, and marks destination byte 0. Cycles with `rx_valid` = 0 are skipped. Bytes after the sixth, and valid bytes that arrive with no start of frame since the last verdict or since reset, do not affect the outputs.
- R8: If a new start of frame arrives before the sixth byte, no `match_vld` pulse is produced for the short frame, and capture restarts.
- R9: A table write whose clock edge comes before the edge that takes the sixth byte is used by that frame's lookup. A write on the same edge is not used.
- R10: With all 64 table bits set and `mcast_en` = 1, every multicast address gives `match_hit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | Receive byte is valid this cycle |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| tbl_we | input | 1 | Table word write strobe |
| tbl_sel | input | 1 | Word select: 0 = bits 31:0, 1 = bits 63:32 |
| tbl_wdata | input | 32 | Table word write data |
| ucast_en | input | 1 | Enables unicast hash matches |
| mcast_en | input | 1 | Enables multicast hash matches |
| match_vld | output | 1 | One-cycle verdict strobe |
| match_hit | output | 1 | Hash match result, held until next start of frame |
| match_mc | output | 1 | Address type of the last verdict: 1 = multicast |

## Verification
Most internal faults in this filter show up in the first verdict that follows them. A wrong byte count moves the `match_vld` pulse by a cycle or drops it. A bad fold or a wrong table word gives the wrong `match_hit` for an address whose index the bench computes on its own. A state that fails to clear lets an old result survive past the next start of frame, and this shows one cycle after that strobe. A reference model is compared with the outputs on every clock, so each of these faults is caught on the cycle it reaches a port.

// File: rtl/dahash_pkg.sv
package dahash_pkg;
  // Verdict produced by one lookup
  typedef struct packed {
    logic hit;
    logic mc;
  } dahash_result_t;
endpackage

// File: rtl/dahash_capture.sv
// Collects the destination address bytes of a frame and flags the sixth.
module dahash_capture #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W    = DATA_W * ADDR_BYTES,
  localparam int HOLD_N    = ADDR_BYTES - 1,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_sof,
  output logic              last_byte,
  output logic [ADDR_W-1:0] lookup_addr
);

  logic [CNT_W-1:0]         cnt;
  logic [HOLD_N*DATA_W-1:0] held;
  logic                     sof_take;
  logic                     mid_take;

  assign sof_take = rx_valid && rx_sof;
  assign mid_take = rx_valid && !rx_sof && (cnt < CNT_W'(ADDR_BYTES));

  // cnt = bytes taken in the current frame; parked at ADDR_BYTES when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(ADDR_BYTES);
    end else if (sof_take) begin
      cnt <= CNT_W'(1);
    end else if (mid_take) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // Only the first ADDR_BYTES-1 bytes are stored; the last is used as it arrives
  always_ff @(posedge clk) begin
    for (int b = 0; b < HOLD_N; b++) begin
      if ((sof_take && b == 0) || (mid_take && cnt == CNT_W'(b))) begin
        held[b*DATA_W +: DATA_W] <= rx_data;
      end
    end
  end

  assign last_byte   = mid_take && (cnt == CNT_W'(ADDR_BYTES - 1));
  assign lookup_addr = {rx_data, held};

endmodule

// File: rtl/dahash_fold.sv
// Folds the address into an index: bit k is the XOR of bits k, k+IDX_W, ...
module dahash_fold #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  for (genvar k = 0; k < IDX_W; k++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int j = k; j < ADDR_W; j += IDX_W) begin
        acc = acc ^ addr[j];
      end
    end
    assign idx[k] = acc;
  end

endmodule

// File: rtl/dahash_table.sv
// Hash table held as software-written words, read one bit at a time.
module dahash_table #(
  parameter int IDX_W      = 6,
  parameter int WORD_W     = 32,
  localparam int TBL_W     = 1 << IDX_W,
  localparam int NUM_WORDS = TBL_W / WORD_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BIT_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  idx,
  output logic              bit_out
);

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [SEL_W-1:0]  rd_word;
  logic [BIT_W-1:0]  rd_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        words[w] <= '0;
      end
    end else if (we) begin
      words[sel] <= wdata;
    end
  end

  if (NUM_WORDS > 1) begin : g_multi
    assign rd_word = idx[IDX_W-1 -: SEL_W];
  end else begin : g_single
    assign rd_word = '0;
  end
  assign rd_bit  = idx[BIT_W-1:0];
  assign bit_out = words[rd_word][rd_bit];

endmodule

// File: rtl/dahash_filter.sv
// Destination address hash filter: top level.
module dahash_filter
  import dahash_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_BYTES  = 6,
  parameter int IDX_W       = 6,
  parameter int WORD_W      = 32,
  localparam int ADDR_W     = DATA_W * ADDR_BYTES,
  localparam int TBL_W      = 1 << IDX_W,
  localparam int NUM_WORDS  = TBL_W / WORD_W,
  localparam int SEL_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              tbl_we,
  input  logic [SEL_W-1:0]  tbl_sel,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic              ucast_en,
  input  logic              mcast_en,
  output logic              match_vld,
  output logic              match_hit,
  output logic              match_mc
);

  logic              last_byte;
  logic [ADDR_W-1:0] lookup_addr;
  logic [IDX_W-1:0]  idx;
  logic              tbl_bit;
  dahash_result_t    res_d;
  dahash_result_t    res_q;

  dahash_capture #(
    .DATA_W     (DATA_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) i_capture (
    .clk         (clk),
    .rst         (rst),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_sof      (rx_sof),
    .last_byte   (last_byte),
    .lookup_addr (lookup_addr)
  );

  dahash_fold #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) i_fold (
    .addr (lookup_addr),
    .idx  (idx)
  );

  dahash_table #(
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W)
  ) i_table (
    .clk     (clk),
    .rst     (rst),
    .we      (tbl_we),
    .sel     (tbl_sel),
    .wdata   (tbl_wdata),
    .idx     (idx),
    .bit_out (tbl_bit)
  );

  // Address bit 0 is the group bit: it picks which enable gates the match
  always_comb begin
    res_d.mc  = lookup_addr[0];
    res_d.hit = tbl_bit && (lookup_addr[0] ? mcast_en : ucast_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_vld <= 1'b0;
      res_q     <= '0;
    end else begin
      match_vld <= last_byte;
      if (last_byte) begin
        res_q <= res_d;
      end else if (rx_valid && rx_sof) begin
        res_q <= '0;
      end
    end
  end

  assign match_hit = res_q.hit;
  assign match_mc  = res_q.mc;

endmodule

// File: rtl/dahash_checker.sv
// Port-level properties of the hash filter, bound to every instance.
module dahash_checker (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_sof,
  input logic ucast_en,
  input logic mcast_en,
  input logic match_vld,
  input logic match_hit,
  input logic match_mc
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !match_vld && !match_hit && !match_mc); // R1

  AST_MC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    match_vld && match_hit && match_mc |-> $past(mcast_en)); // R4

  AST_UC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    match_vld && match_hit && !match_mc |-> $past(ucast_en)); // R4

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_vld |=> !match_vld); // R5

  AST_VLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    match_vld |-> $past(rx_valid && !rx_sof)); // R7

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_sof |=> !match_vld && !match_hit && !match_mc); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !match_vld && $past(!(rx_valid && rx_sof)) |-> $stable(match_hit) && $stable(match_mc)); // R6

endmodule

bind dahash_filter dahash_checker i_checker (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .rx_sof    (rx_sof),
  .ucast_en  (ucast_en),
  .mcast_en  (mcast_en),
  .match_vld (match_vld),
  .match_hit (match_hit),
  .match_mc  (match_mc)
);

// File: tb/test_dahash_filter.sv
`timescale 1ns/1ps
module test_dahash_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [31:0] tbl_wdata = '0;
  logic        ucast_en = 1'b0;
  logic        mcast_en = 1'b0;
  logic        match_vld;
  logic        match_hit;
  logic        match_mc;

  int nchecks = 0;
  int nerrs   = 0;
  int pulses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dahash_filter i_dahash_filter (
    .clk       (clk),
    .rst       (rst),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel),
    .tbl_wdata (tbl_wdata),
    .ucast_en  (ucast_en),
    .mcast_en  (mcast_en),
    .match_vld (match_vld),
    .match_hit (match_hit),
    .match_mc  (match_mc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int idx_of(input logic [47:0] da);
    int r = 0;
    for (int b = 0; b < 48; b++) begin
      if (da[b]) r = r ^ (1 << (b % 6));
    end
    return r;
  endfunction

  // ---------------- reference model ----------------
  logic [63:0] m_tbl;
  logic [7:0]  q[$];
  bit          m_act;
  bit          e_vld, e_hit, e_mc;
  logic [47:0] m_da;

  always @(posedge clk) begin
    if (rst) begin
      m_tbl = '0; q.delete(); m_act = 0; e_vld = 0; e_hit = 0; e_mc = 0;
    end else begin
      e_vld = 0;
      if (rx_valid && rx_sof) begin
        q.delete(); q.push_back(rx_data); m_act = 1; e_hit = 0; e_mc = 0;
      end else if (rx_valid && m_act && q.size() < 6) begin
        q.push_back(rx_data);
        if (q.size() == 6) begin
          for (int i = 0; i < 6; i++) m_da[8*i +: 8] = q[i];
          e_vld = 1;
          e_mc  = m_da[0];
          e_hit = m_tbl[idx_of(m_da)] && (m_da[0] ? mcast_en : ucast_en);
          m_act = 0;
        end
      end
      if (tbl_we) begin
        if (tbl_sel) m_tbl[63:32] = tbl_wdata;
        else         m_tbl[31:0]  = tbl_wdata;
      end
    end
  end

  // per-cycle comparison and pulse monitor, away from the active edge
  logic last_hit, last_mc;
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(match_vld === e_vld, "R5 match_vld", 64'(match_vld), 64'(e_vld));
      chk(match_hit === e_hit, "R4 match_hit", 64'(match_hit), 64'(e_hit));
      chk(match_mc  === e_mc,  "R6 match_mc",  64'(match_mc),  64'(e_mc));
      if (match_vld) begin
        pulses++; last_hit = match_hit; last_mc = match_mc;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); tbl_we = 1; tbl_sel = sel; tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic set_bit(input int k);
    wr(1'b0, '0); wr(1'b1, '0);
    wr(k >= 32, 32'h1 << (k % 32));
  endtask

  task automatic frame(input logic [47:0] da, input int nbytes, input bit gaps,
                       input int wr_at, input logic sel, input logic [31:0] wd);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      if (gaps && i > 0) begin
        rx_valid = 0; rx_sof = 0; tbl_we = 0; rx_data = 8'h3C;
        @(negedge clk);
      end
      rx_valid  = 1;
      rx_sof    = (i == 0);
      rx_data   = (i < 6) ? da[8*i +: 8] : 8'hA5;
      tbl_we    = (i == wr_at);
      tbl_sel   = sel;
      tbl_wdata = wd;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; tbl_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_frame(input logic [47:0] da, input bit hit, input string tag);
    int p0 = pulses;
    frame(da, 6, 0, -1, 0, '0);
    chk(pulses == p0 + 1, tag, 64'(pulses - p0), 64'd1);
    chk(last_hit == hit, tag, 64'(last_hit), 64'(hit));
  endtask

  // ---------------- directed sequence ----------------
  localparam logic [47:0] ADDR_A = 48'h5E33_00A1_C402;  // unicast
  localparam logic [47:0] ADDR_C = 48'h0000_0000_0021;  // multicast, index 33

  initial begin
    int p0;
    int ka;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(!match_vld && !match_hit && !match_mc, "R1 reset outputs",
        {61'd0, match_vld, match_hit, match_mc}, 64'd0);

    // R7: valid bytes before any start of frame do nothing
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_data = 8'(i);
    end
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);
    chk(pulses == p0, "R7 bytes without sof", 64'(pulses - p0), 64'd0);

    // R1: cleared table never hits
    ucast_en = 1; mcast_en = 1;
    expect_frame(ADDR_A, 0, "R1 empty table unicast");
    expect_frame(ADDR_C, 0, "R1 empty table multicast");

    // R2 / R3: bottom word bit at computed index
    ka = idx_of(ADDR_A);
    set_bit(ka);
    expect_frame(ADDR_A, 1, "R3 index hit");
    chk(last_mc == 0, "R6 unicast type", 64'(last_mc), 64'd0);
    expect_frame(ADDR_A ^ 48'h2, 0, "R3 other index misses");

    // R4: unicast disabled
    ucast_en = 0;
    expect_frame(ADDR_A, 0, "R4 unicast disabled");
    ucast_en = 1;

    // R2 / R4 / R6: top word, multicast
    chk(idx_of(ADDR_C) == 33, "R3 index of C", 64'(idx_of(ADDR_C)), 64'd33);
    set_bit(33);
    expect_frame(ADDR_C, 1, "R2 top word hit");
    chk(last_mc == 1, "R6 multicast type", 64'(last_mc), 64'd1);
    repeat (5) @(negedge clk);
    chk(match_hit == 1 && match_mc == 1, "R6 result held", {62'd0, match_hit, match_mc}, 64'd3);

    // R8 / R6: short frame clears result and gives no pulse
    p0 = pulses;
    frame(ADDR_C, 3, 0, -1, 0, '0);
    chk(pulses == p0, "R8 short frame no pulse", 64'(pulses - p0), 64'd0);
    chk(match_hit == 0 && match_mc == 0, "R6 cleared by sof", {62'd0, match_hit, match_mc}, 64'd0);
    // short frame cut by a new frame
    p0 = pulses;
    frame(ADDR_A, 4, 0, -1, 0, '0);
    frame(ADDR_C, 6, 0, -1, 0, '0);
    chk(pulses == p0 + 1, "R8 restart after short frame", 64'(pulses - p0), 64'd1);
    chk(last_hit == 1, "R8 restarted frame result", 64'(last_hit), 64'd1);

    mcast_en = 0;
    expect_frame(ADDR_C, 0, "R4 multicast disabled");
    mcast_en = 1;

    // R7: gaps and trailing bytes
    set_bit(ka);
    p0 = pulses;
    frame(ADDR_A, 12, 1, -1, 0, '0);
    chk(pulses == p0 + 1, "R7 gaps and tail one pulse", 64'(pulses - p0), 64'd1);
    chk(last_hit == 1, "R7 gapped frame hit", 64'(last_hit), 64'd1);

    // R9: write on the sixth-byte edge is too late, earlier is in time
    wr(1'b0, '0); wr(1'b1, '0);
    p0 = pulses;
    frame(ADDR_A, 6, 0, 5, ka >= 32, 32'h1 << (ka % 32));
    chk(last_hit == 0 && pulses == p0 + 1, "R9 same-edge write unused", 64'(last_hit), 64'd0);
    expect_frame(ADDR_A, 1, "R9 write seen next frame");
    wr(1'b0, '0); wr(1'b1, '0);
    frame(ADDR_A, 6, 0, 4, ka >= 32, 32'h1 << (ka % 32));
    chk(last_hit == 1, "R9 earlier write used", 64'(last_hit), 64'd1);

    // R10: all ones, multicast always hits
    wr(1'b0, '1); wr(1'b1, '1);
    ucast_en = 0; mcast_en = 1;
    for (int i = 0; i < 10; i++) begin
      logic [47:0] d;
      d = {16'(i * 97 + 3), 32'(32'h9E37_79B9 * (i + 1))};
      d[0] = 1'b1;
      expect_frame(d, 1, "R10 all-ones multicast");
      d[0] = 1'b0;
      expect_frame(d, 0, "R10 unicast still gated");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchecks++; nerrs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

endmodule